// File: doc/BRIEF.md
# Key Matrix Change Event Encoder

This block sits behind a keyboard matrix scanner. For each of eight scan columns it remembers the last 16-bit row pattern that was sensed. Each sense line is active low, so a 0 bit means the key at that row is held down. The scanner hands over one column at a time: a column index and the raw sense word for that column. The block compares the word with the stored pattern for that column and writes the new word into the store. It then emits one key event for every row whose bit differs from the stored pattern.

Events leave one per handshake on a valid/ready output port. Each event has a press/release flag and a key code equal to row times eight plus column. Changed rows are reported from the lowest row number to the highest. While events from a sample are still pending, the block will not take another sample.

After reset the stored patterns hold a non-idle value in which row 13 of every column counts as already pressed. The first scan of an idle matrix therefore reports a release at row 13 for each column. An `enable` input mutes event generation but still lets samples refresh the store.

Top module: `keymatrix_event_encoder`

## Requirements
- R1: A synchronous `rst` sets all eight stored patterns to 16'hDFFF, so row 13 counts as pressed. It also drops `evt_valid`, discards pending events and leaves `sample_ready` high.
- R2: If an accepted sample equals the stored pattern for its column, no event is produced and `sample_ready` stays high.
- R3: If an accepted sample differs from the stored pattern, the stored pattern for that column becomes the sample. Later samples are compared against it.
- R4: The events from one sample come out in ascending row order, from row 0 to row 15, one for each row bit that changed.
- R5: `evt_press` is 1 (press) when the new bit for that row is 0, and 0 (release) when the new bit is 1.
- R6: `evt_code` is the 7-bit value row*8 + column.
- R7: A sample is taken on a clock edge where `sample_valid` and `sample_ready` are both high. If it yields events, `sample_ready` is low from the next cycle until the last event has been taken. The first event's `evt_valid` rises on the second edge after acceptance.
- R8: While `evt_valid` is high and `evt_ready` is low, `evt_code` and `evt_press` hold steady and `evt_valid` stays high.
- R9: A sample accepted while `enable` is low updates the store but produces no events, and `sample_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows events to be generated from accepted samples |
| sample_valid | input | 1 | A column sample is offered |
| sample_ready | output | 1 | The block can take a sample |
| sample_col | input | 3 | Column index of the sample |
| sample_data | input | 16 | Active-low row sense word |
| evt_valid | output | 1 | An event is offered |
| evt_ready | input | 1 | The consumer takes the event |
| evt_press | output | 1 | 1 = press, 0 = release |
| evt_code | output | 7 | Key code, row*8 + column |

## Verification
The bench builds the block with its default sizes of eight columns and sixteen rows. At these sizes the top key code, 127, and a sample that flips all sixteen rows at once can be reached, along with the reset pattern's row-13 bit. The vector table drives untouched columns, single-bit and two-bit changes at both ends of the row range, and a muted sample followed by a repeat of it. During the drain the consumer applies back-pressure in an irregular pattern. A reset in the middle of a burst is checked separately.

// File: rtl/kme_pkg.sv
package kme_pkg;
  localparam int unsigned KME_COLS_DEF = 8;
  localparam int unsigned KME_ROWS_DEF = 16;
  localparam logic [15:0] KME_IDLE_DEF = 16'hDFFF;

  typedef enum logic {
    EV_RELEASE = 1'b0,
    EV_PRESS   = 1'b1
  } ev_kind_e;
endpackage

// File: rtl/kme_pattern_store.sv
module kme_pattern_store #(
  parameter int unsigned COLS = 8,
  parameter int unsigned ROWS = 16,
  parameter logic [ROWS-1:0] RST_PAT = '1,
  localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] rd_col,
  output logic [ROWS-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [ROWS-1:0]  wr_data
);
  logic [ROWS-1:0] pat_q [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst) pat_q[c] <= RST_PAT;
      else if (wr_en && (wr_col == COL_W'(c))) pat_q[c] <= wr_data;
    end

    // R1: every column pattern is restored by reset
    a_r1_store_preset: assert property (@(posedge clk)
      rst |=> (pat_q[c] == RST_PAT));
  end

  assign rd_data = pat_q[rd_col];
endmodule

// File: rtl/kme_row_picker.sv
module kme_row_picker #(
  parameter int unsigned ROWS = 16,
  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [ROWS-1:0]  mask,
  output logic             found,
  output logic [ROW_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (mask[r]) begin
        found = 1'b1;
        idx   = ROW_W'(r);
      end
    end
  end

  // R4: the chosen row is a set bit with no lower set bit
  always_comb begin
    if (found) begin
      a_r4_lowest_pick: assert ((mask[idx] == 1'b1) &&
                                ((mask & ((ROWS'(1) << idx) - ROWS'(1))) == '0));
    end
  end
endmodule

// File: rtl/keymatrix_event_encoder.sv
module keymatrix_event_encoder
  import kme_pkg::*;
#(
  parameter int unsigned COLS = KME_COLS_DEF,
  parameter int unsigned ROWS = KME_ROWS_DEF,
  parameter logic [ROWS-1:0] IDLE_PAT = ROWS'(KME_IDLE_DEF),
  localparam int unsigned COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned CODE_W = $clog2(ROWS * COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              sample_valid,
  output logic              sample_ready,
  input  logic [COL_W-1:0]  sample_col,
  input  logic [ROWS-1:0]   sample_data,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic              evt_press,
  output logic [CODE_W-1:0] evt_code
);
  logic [ROWS-1:0]   stored;
  logic [ROWS-1:0]   diff;
  logic              sample_fire;
  logic [ROWS-1:0]   pending_q;
  logic [ROWS-1:0]   data_q;
  logic [COL_W-1:0]  col_q;
  logic              pick_found;
  logic [ROW_W-1:0]  pick_idx;
  logic              load_evt;
  logic              evt_valid_q;
  ev_kind_e          evt_kind_q;
  logic [CODE_W-1:0] evt_code_q;

  assign sample_ready = !evt_valid_q && (pending_q == '0);
  assign sample_fire  = sample_valid && sample_ready;
  assign diff         = sample_data ^ stored;

  kme_pattern_store #(.COLS(COLS), .ROWS(ROWS), .RST_PAT(IDLE_PAT)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_col  (sample_col),
    .rd_data (stored),
    .wr_en   (sample_fire && (diff != '0)),
    .wr_col  (sample_col),
    .wr_data (sample_data)
  );

  kme_row_picker #(.ROWS(ROWS)) u_pick (
    .mask  (pending_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign load_evt = pick_found && (!evt_valid_q || evt_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q   <= '0;
      data_q      <= '0;
      col_q       <= '0;
      evt_valid_q <= 1'b0;
      evt_kind_q  <= EV_RELEASE;
      evt_code_q  <= '0;
    end else begin
      if (sample_fire) begin
        pending_q <= enable ? diff : '0;
        data_q    <= sample_data;
        col_q     <= sample_col;
      end else if (load_evt) begin
        pending_q <= pending_q & ~(ROWS'(1) << pick_idx);
      end

      if (load_evt) begin
        evt_valid_q <= 1'b1;
        evt_kind_q  <= data_q[pick_idx] ? EV_RELEASE : EV_PRESS;
        evt_code_q  <= CODE_W'(pick_idx) * CODE_W'(COLS) + CODE_W'(col_q);
      end else if (evt_ready) begin
        evt_valid_q <= 1'b0;
      end
    end
  end

  assign evt_valid = evt_valid_q;
  assign evt_press = (evt_kind_q == EV_PRESS);
  assign evt_code  = evt_code_q;

  // R8: an offered event is held until taken
  a_r8_hold_event: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code) && $stable(evt_press)));

  // R4: back-to-back events from one sample have rising codes
  a_r4_rising_codes: assert property (@(posedge clk) disable iff (rst)
    ($past(evt_valid && evt_ready) && evt_valid) |-> (evt_code > $past(evt_code)));

  // R7: no event appears on the edge right after acceptance
  a_r7_no_early_event: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && sample_ready && !evt_valid) |=> !evt_valid);

  // R9: a muted sample leaves nothing to drain
  a_r9_muted_sample: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && sample_ready && !enable) |=> (sample_ready && !evt_valid));
endmodule

// File: tb/keymatrix_event_encoder_test.sv
module keymatrix_event_encoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b1;
  logic        sample_valid = 1'b0;
  logic        sample_ready;
  logic [2:0]  sample_col = '0;
  logic [15:0] sample_data = '0;
  logic        evt_valid;
  logic        evt_ready = 1'b0;
  logic        evt_press;
  logic [6:0]  evt_code;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  keymatrix_event_encoder uut (
    .clk(clk), .rst(rst), .enable(enable),
    .sample_valid(sample_valid), .sample_ready(sample_ready),
    .sample_col(sample_col), .sample_data(sample_data),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_press(evt_press), .evt_code(evt_code)
  );

  // vector: col, data, enable, count, first code, first press, last code, last press
  typedef struct packed {
    logic [2:0]  col;
    logic [15:0] data;
    logic        en;
    logic [4:0]  cnt;
    logic [6:0]  f_code;
    logic        f_press;
    logic [6:0]  l_code;
    logic        l_press;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'hDFFF, 1'b1, 5'd0,  7'd0,   1'b0, 7'd0,   1'b0}, // R1 R2
    '{3'd0, 16'hFFFF, 1'b1, 5'd1,  7'd104, 1'b0, 7'd104, 1'b0}, // R1 R5 R6
    '{3'd3, 16'hDFFE, 1'b1, 5'd1,  7'd3,   1'b1, 7'd3,   1'b1}, // R5 R6
    '{3'd3, 16'h5FFF, 1'b1, 5'd2,  7'd3,   1'b0, 7'd123, 1'b1}, // R3 R4
    '{3'd7, 16'hFFFF, 1'b0, 5'd0,  7'd0,   1'b0, 7'd0,   1'b0}, // R9
    '{3'd7, 16'hFFFF, 1'b1, 5'd0,  7'd0,   1'b0, 7'd0,   1'b0}, // R9 R3
    '{3'd7, 16'h0000, 1'b1, 5'd16, 7'd7,   1'b1, 7'd127, 1'b1}, // R4 R6
    '{3'd5, 16'hDFFF, 1'b1, 5'd0,  7'd0,   1'b0, 7'd0,   1'b0}, // R2
    '{3'd5, 16'hDF7F, 1'b1, 5'd1,  7'd61,  1'b1, 7'd61,  1'b1}, // R6
    '{3'd0, 16'hFFFF, 1'b1, 5'd0,  7'd0,   1'b0, 7'd0,   1'b0}  // R3
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic offer(input logic [2:0] c, input logic [15:0] d, input logic en);
    @(negedge clk);
    sample_col = c; sample_data = d; enable = en; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  // Called right after offer(): one edge has passed since acceptance.
  task automatic drain(input vec_t v, input int idx);
    int got = 0;
    int prev = -1;
    bit held = 0;
    logic [6:0] h_code;
    logic h_press;
    int pat = idx;
    if (v.cnt == 0) begin
      chk(sample_ready == 1'b1, "R2/R9 ready stays high", sample_ready, 1);
      chk(evt_valid == 1'b0, "R2/R9 no event", evt_valid, 0);
      return;
    end
    chk(sample_ready == 1'b0, "R7 ready low while busy", sample_ready, 0);
    chk(evt_valid == 1'b0, "R7 no event one edge after accept", evt_valid, 0);
    @(negedge clk);
    chk(evt_valid == 1'b1, "R7 event on second edge", evt_valid, 1);
    for (int g = 0; g < 200 && got < v.cnt; g++) begin
      if (evt_valid) begin
        if (sample_ready) chk(0, "R7 ready high during drain", 1, 0);
        if (held) begin
          chk(evt_code == h_code && evt_press == h_press, "R8 held event stable",
              evt_code, h_code);
        end
        pat++;
        if ((pat % 3) == 1) begin
          evt_ready = 1'b0;
          held = 1; h_code = evt_code; h_press = evt_press;
        end else begin
          evt_ready = 1'b1;
          held = 0;
          if (got == 0) begin
            chk(evt_code == v.f_code, "R6 first code", evt_code, v.f_code);
            chk(evt_press == v.f_press, "R5 first kind", evt_press, v.f_press);
          end
          if (got == v.cnt - 1) begin
            chk(evt_code == v.l_code, "R6 last code", evt_code, v.l_code);
            chk(evt_press == v.l_press, "R5 last kind", evt_press, v.l_press);
          end
          if (prev >= 0 && int'(evt_code) <= prev)
            chk(0, "R4 ascending rows", evt_code, prev + 8);
          prev = evt_code;
          got++;
        end
      end else begin
        evt_ready = 1'b0;
      end
      @(negedge clk);
    end
    evt_ready = 1'b0;
    chk(got == v.cnt, "R4 event count", got, v.cnt);
    chk(evt_valid == 1'b0, "R7 drained", evt_valid, 0);
    chk(sample_ready == 1'b1, "R7 ready back high", sample_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(evt_valid == 1'b0, "R1 reset evt_valid", evt_valid, 0);
    chk(sample_ready == 1'b1, "R1 reset sample_ready", sample_ready, 1);

    for (int i = 0; i < NV; i++) begin
      offer(VECS[i].col, VECS[i].data, VECS[i].en);
      drain(VECS[i], i);
    end

    // R1: reset during a burst clears events and restores store
    offer(3'd2, 16'h0FFF, 1'b1);
    @(negedge clk);
    chk(evt_valid == 1'b1, "R7 burst started", evt_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(evt_valid == 1'b0, "R1 reset drops event", evt_valid, 0);
    chk(sample_ready == 1'b1, "R1 reset frees input", sample_ready, 1);
    @(negedge clk);
    chk(evt_valid == 1'b0, "R1 no leftover event", evt_valid, 0);
    offer(3'd2, 16'hDFFF, 1'b1);
    chk(sample_ready == 1'b1 && evt_valid == 1'b0, "R1 col2 preset after reset",
        evt_valid, 0);
    offer(3'd7, 16'hDFFF, 1'b1);
    chk(sample_ready == 1'b1 && evt_valid == 1'b0, "R1 col7 preset after reset",
        evt_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule